// File: doc/BRIEF.md
# Peak-Normalising Vector Front End for an Analog Multiply Engine

This block sits between a digital error vector and an analog vector-matrix multiply engine. Small error values give little signal at the engine's output, so the result is mostly noise. To avoid this, the block first finds the largest magnitude in the vector. It then divides every element by that peak, so that the largest element is driven at full scale, which is the longest pulse duration. The scaled vector goes to the engine through a request/acknowledge handshake. When the results come back, each one is multiplied by the same peak, so the numeric scale of the computation is restored. The signal-to-noise ratio at the engine then stays fixed however small the errors become.

A vector is `N_ELEM` signed Q8.8 elements. Element k sits at bits `[16k+15:16k]` of the flat ports. The engine side uses Q1.15 inputs and Q5.15 results, and element k of the results sits at bits `[20k+19:20k]`.

The block works in two passes. The first pass searches for the peak, one element per cycle. The second pass divides one element at a time through a single sequential restoring divider. A bypass mode skips both passes for inputs already known to lie in [-1, 1], such as forward-cycle activations. If the peak is zero, the block skips the engine and returns zeros.

Top module: `nm_vec_normaliser`

## Requirements
- R1: A `start_i` pulse while `busy_o` is low, with `bypass_i` low, latches `vec_i` and finds the peak P. P is the largest element magnitude, and -32768 has magnitude 32768.
- R2: With P nonzero, element x is sent to the engine as follows, where q = floor(|x|·32768/P):
  - a negative x is sent as -q;
  - a non-negative x is sent as min(q, 32767).
  - As a result, at least one element is 0x7FFF or 0x8000.
- R3: `eng_req_o` rises once the vector is ready. It then stays high, with `eng_vec_o` stable, until the first cycle in which `eng_ack_i` is high.
- R4: When the acknowledge is accepted, each Q5.15 result r is rescaled. The value floor(r·S/32768) is returned on `res_o`, saturated to [-32768, 32767]. S is P in normal mode and 256 in bypass.
- R5: With `bypass_i` high at start, no peak search or division is done:
  - each element is sent as x·128, saturated to [-32768, 32767];
  - a request is always raised, even for an all-zero vector;
  - the scale S is 256.
- R6: With P equal to zero in normal mode, no request is raised. `done_o` fires with `res_o` all zero.
- R7: `done_o` is high for exactly one cycle per transaction. `res_o` holds its value until the next completion.
- R8: `start_i` is ignored while `busy_o` is high. The transaction in flight completes with the vector it latched, and no further transaction starts.
- R9: After reset, `busy_o`, `eng_req_o` and `done_o` are low and `res_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transaction (accepted only when idle) |
| bypass_i | input | 1 | Skip normalisation for vectors within [-1, 1] |
| vec_i | input | N_ELEM*16 | Input vector, signed Q8.8 per element |
| busy_o | output | 1 | Transaction in progress |
| eng_req_o | output | 1 | Engine request, held until acknowledged |
| eng_vec_o | output | N_ELEM*16 | Scaled vector to engine, signed Q1.15 |
| eng_ack_i | input | 1 | Engine acknowledge, results valid |
| eng_res_i | input | N_ELEM*20 | Engine results, signed Q5.15 |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | N_ELEM*16 | Rescaled results, signed Q8.8 |

## Verification
The embedded assertions check the following on every cycle:
- the request stays held and the vector stays stable until acknowledge;
- the peak never falls during a scan;
- each quotient stays within full scale, and every normalised request carries a full-scale element;
- a zero peak goes straight to a cleared result;
- `done_o` is a single pulse;
- the latched vector stays frozen while busy.

The bench scenarios cover the following, comparing against a behavioural model:
- the exact arithmetic of division and rescaling, including floor behaviour for negative values;
- the saturation corners at both ends and the -32768 peak;
- the bypass conversion;
- the rejection of a second start request.

// File: rtl/nm_pkg.sv
package nm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_CHK,
    ST_DIV,
    ST_REQ,
    ST_DONE
  } nm_state_e;
endpackage

// File: rtl/nm_peak_scan.sv
module nm_peak_scan #(
  parameter int D_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  en_i,
  input  logic signed [D_W-1:0] val_i,
  output logic        [D_W:0]   peak_o
);
  logic signed [D_W:0] ext;
  logic        [D_W:0] mag;

  always_comb begin
    ext = {val_i[D_W-1], val_i};
    mag = ext[D_W] ? (D_W+1)'(-ext) : (D_W+1)'(ext);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  peak_o <= '0;
    else if (clr_i)               peak_o <= '0;
    else if (en_i && mag > peak_o) peak_o <= mag;
  end

  assert_peak_monotonic_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> peak_o >= $past(peak_o));
endmodule

// File: rtl/nm_restoring_div.sv
module nm_restoring_div #(
  parameter int MW = 17,
  parameter int QW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [MW-1:0] num_i,   // caller guarantees num_i <= den_i
  input  logic [MW-1:0] den_i,
  output logic          done_o,
  output logic [QW-1:0] quo_o
);
  localparam int CW = $clog2(QW + 1);

  logic [MW:0]   rem_q;
  logic [MW-1:0] den_q;
  logic [CW-1:0] cnt_q;
  logic          first_q;
  logic          busy_q;
  logic [MW:0]   trial;
  logic          ge;

  // first step weighs the integer bit, later steps shift in one fraction bit each
  always_comb begin
    trial = first_q ? rem_q : {rem_q[MW-1:0], 1'b0};
    ge    = trial >= {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      den_q   <= '0;
      cnt_q   <= '0;
      first_q <= 1'b0;
      busy_q  <= 1'b0;
      quo_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q   <= {1'b0, num_i};
        den_q   <= den_i;
        cnt_q   <= CW'(QW);
        first_q <= 1'b1;
        busy_q  <= 1'b1;
        quo_o   <= '0;
      end else if (busy_q) begin
        rem_q   <= ge ? trial - {1'b0, den_q} : trial;
        quo_o   <= {quo_o[QW-2:0], ge};
        first_q <= 1'b0;
        cnt_q   <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assert_quot_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> quo_o <= {1'b1, {(QW-1){1'b0}}});
  assert_start_when_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/nm_rescale.sv
module nm_rescale #(
  parameter int N_ELEM = 4,
  parameter int R_W    = 20,
  parameter int S_W    = 17,
  parameter int D_W    = 16,
  parameter int FRAC   = 15
) (
  input  logic [N_ELEM*R_W-1:0] res_i,
  input  logic [S_W-1:0]        scale_i,
  output logic [N_ELEM*D_W-1:0] res_o
);
  localparam int PW = R_W + S_W + 1;
  localparam logic [D_W-1:0] SAT_POS = {1'b0, {(D_W-1){1'b1}}};
  localparam logic [D_W-1:0] SAT_NEG = {1'b1, {(D_W-1){1'b0}}};

  for (genvar k = 0; k < N_ELEM; k++) begin : g_el
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shf;
    always_comb begin
      prod = $signed(res_i[k*R_W +: R_W]) * $signed({1'b0, scale_i});
      shf  = prod >>> FRAC;
      if (shf[PW-1:D_W-1] == '0 || shf[PW-1:D_W-1] == '1)
        res_o[k*D_W +: D_W] = shf[D_W-1:0];
      else
        res_o[k*D_W +: D_W] = shf[PW-1] ? SAT_NEG : SAT_POS;
    end
  end
endmodule

// File: rtl/nm_vec_normaliser.sv
module nm_vec_normaliser
  import nm_pkg::*;
#(
  parameter int N_ELEM = 4,
  parameter int D_W    = 16,
  parameter int D_FRAC = 8,
  parameter int E_W    = 16,
  parameter int R_W    = 20
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  bypass_i,
  input  logic [N_ELEM*D_W-1:0] vec_i,
  output logic                  busy_o,
  output logic                  eng_req_o,
  output logic [N_ELEM*E_W-1:0] eng_vec_o,
  input  logic                  eng_ack_i,
  input  logic [N_ELEM*R_W-1:0] eng_res_i,
  output logic                  done_o,
  output logic [N_ELEM*D_W-1:0] res_o
);
  localparam int E_FRAC = E_W - 1;
  localparam int M_W    = D_W + 1;
  localparam int IW     = (N_ELEM > 1) ? $clog2(N_ELEM) : 1;
  localparam int BYP_SH = E_FRAC - D_FRAC;
  localparam int BW     = D_W + BYP_SH;
  localparam logic [M_W-1:0] UNITY  = M_W'(1) << D_FRAC;
  localparam logic [E_W-1:0] FS_POS = {1'b0, {(E_W-1){1'b1}}};
  localparam logic [E_W-1:0] FS_NEG = {1'b1, {(E_W-1){1'b0}}};
  localparam logic [IW-1:0]  LAST   = IW'(N_ELEM - 1);

  nm_state_e             state_q;
  logic [IW-1:0]         idx_q;
  logic [N_ELEM*D_W-1:0] vec_q;
  logic                  byp_q;
  logic [M_W-1:0]        scale_q;
  logic [N_ELEM*E_W-1:0] evec_q;
  logic [N_ELEM*D_W-1:0] res_q;

  logic [M_W-1:0]        peak;
  logic [N_ELEM*E_W-1:0] byp_vec;
  logic [N_ELEM*D_W-1:0] resc;
  logic                  div_start;
  logic                  div_done;
  logic [E_W-1:0]        quo;
  logic [IW-1:0]         sel;
  logic signed [D_W:0]   sel_ext;
  logic [M_W-1:0]        sel_mag;
  logic                  cur_neg;
  logic [E_W-1:0]        quo_signed;
  logic                  fs_hit;

  // bypass: Q8.8 to Q1.15 by shift, saturated
  for (genvar k = 0; k < N_ELEM; k++) begin : g_byp
    logic [BW-1:0] sh;
    assign sh = {vec_i[k*D_W +: D_W], {BYP_SH{1'b0}}};
    assign byp_vec[k*E_W +: E_W] =
      (sh[BW-1:E_W-1] == '0 || sh[BW-1:E_W-1] == '1) ? sh[E_W-1:0]
                                                     : (sh[BW-1] ? FS_NEG : FS_POS);
  end

  nm_peak_scan #(.D_W(D_W)) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_IDLE && start_i),
    .en_i   (state_q == ST_SCAN),
    .val_i  ($signed(vec_q[idx_q*D_W +: D_W])),
    .peak_o (peak)
  );

  always_comb begin
    sel       = (state_q == ST_CHK) ? '0 : idx_q + IW'(1);
    sel_ext   = {vec_q[sel*D_W + (D_W-1)], vec_q[sel*D_W +: D_W]};
    sel_mag   = sel_ext[D_W] ? M_W'(-sel_ext) : M_W'(sel_ext);
    div_start = (state_q == ST_CHK && peak != '0) ||
                (state_q == ST_DIV && div_done && idx_q != LAST);
    cur_neg   = vec_q[idx_q*D_W + (D_W-1)];
    if (cur_neg)         quo_signed = -quo;
    else if (quo[E_W-1]) quo_signed = FS_POS;
    else                 quo_signed = quo;
  end

  nm_restoring_div #(.MW(M_W), .QW(E_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (sel_mag),
    .den_i   (peak),
    .done_o  (div_done),
    .quo_o   (quo)
  );

  nm_rescale #(
    .N_ELEM (N_ELEM),
    .R_W    (R_W),
    .S_W    (M_W),
    .D_W    (D_W),
    .FRAC   (E_FRAC)
  ) u_resc (
    .res_i   (eng_res_i),
    .scale_i (scale_q),
    .res_o   (resc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      vec_q   <= '0;
      byp_q   <= 1'b0;
      scale_q <= '0;
      evec_q  <= '0;
      res_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          vec_q <= vec_i;
          byp_q <= bypass_i;
          idx_q <= '0;
          if (bypass_i) begin
            evec_q  <= byp_vec;
            scale_q <= UNITY;
            state_q <= ST_REQ;
          end else begin
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (idx_q == LAST) state_q <= ST_CHK;
          else               idx_q   <= idx_q + IW'(1);
        end
        ST_CHK: begin
          if (peak == '0) begin
            res_q   <= '0;
            state_q <= ST_DONE;
          end else begin
            scale_q <= peak;
            idx_q   <= '0;
            state_q <= ST_DIV;
          end
        end
        ST_DIV: if (div_done) begin
          evec_q[idx_q*E_W +: E_W] <= quo_signed;
          if (idx_q == LAST) state_q <= ST_REQ;
          else               idx_q   <= idx_q + IW'(1);
        end
        ST_REQ: if (eng_ack_i) begin
          res_q   <= resc;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign eng_req_o = (state_q == ST_REQ);
  assign done_o    = (state_q == ST_DONE);
  assign eng_vec_o = evec_q;
  assign res_o     = res_q;

  always_comb begin
    fs_hit = 1'b0;
    for (int k = 0; k < N_ELEM; k++)
      if (evec_q[k*E_W +: E_W] == FS_POS || evec_q[k*E_W +: E_W] == FS_NEG) fs_hit = 1'b1;
  end

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && !eng_ack_i |=> eng_req_o && $stable(eng_vec_o));
  assert_full_scale_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && !byp_q |-> fs_hit);
  assert_bypass_unity_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && byp_q |-> scale_q == UNITY);
  assert_zero_skip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CHK && peak == '0 |=> done_o && res_o == '0 && !eng_req_o);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(vec_q));
endmodule

// File: tb/sim_nm_vec_normaliser.sv
module sim_nm_vec_normaliser;
  localparam int N = 4, DW = 16, EW = 16, RW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic            start = 1'b0, byp = 1'b0, ack = 1'b0;
  logic [N*DW-1:0] vec = '0;
  logic [N*RW-1:0] eres = '0;
  logic            busy, req, done;
  logic [N*EW-1:0] evec;
  logic [N*DW-1:0] res;

  nm_vec_normaliser u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bypass_i(byp), .vec_i(vec),
    .busy_o(busy), .eng_req_o(req), .eng_vec_o(evec), .eng_ack_i(ack),
    .eng_res_i(eres), .done_o(done), .res_o(res)
  );

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // per-cycle handshake model, sampled 1 ns before each rising edge (R3)
  logic            m_req = 1'b0, m_ack = 1'b0;
  logic [N*EW-1:0] m_vec = '0;
  always @(negedge clk) begin
    #3;
    if (rst_n && m_req && !m_ack) begin
      chk("R3 request held", req, 1);
      chk("R3 vector stable", (evec == m_vec), 1);
    end
    m_req = req; m_ack = ack; m_vec = evec;
  end

  int tv[N];
  bit tbyp;
  int mult;

  function automatic longint clamp16(input longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int peak_of();
    int p = 0;
    for (int k = 0; k < N; k++) begin
      int m = (tv[k] < 0) ? -tv[k] : tv[k];
      if (m > p) p = m;
    end
    return p;
  endfunction

  function automatic longint norm_of(input int x, input int p);
    int m = (x < 0) ? -x : x;
    longint q = (longint'(m) * 32768) / p;
    if (x < 0) return -q;
    return (q > 32767) ? 32767 : q;
  endfunction

  function automatic longint resc_of(input longint r, input int s);
    longint pr = r * s;
    return clamp16(pr >>> 15);
  endfunction

  task automatic run(input string tag, input bit ignore_start);
    int      p, s, t;
    bit      fs;
    longint  er[N];
    longint  exp_res[N];
    @(negedge clk);
    for (int k = 0; k < N; k++) vec[k*DW +: DW] = DW'(tv[k]);
    byp = tbyp;
    start = 1'b1;
    @(negedge clk);
    if (ignore_start) begin
      vec = ~vec; byp = ~tbyp;
      repeat (3) @(negedge clk);
    end
    start = 1'b0;
    p = peak_of();
    s = tbyp ? 256 : p;
    t = 0;
    while (!req && !done && t < 3000) begin @(negedge clk); t++; end
    if (!tbyp && p == 0) begin
      chk({tag, " R6 no request"}, req, 0);
      chk({tag, " R6 done"}, done, 1);
      for (int k = 0; k < N; k++) chk({tag, " R6 zero result"}, $signed(res[k*DW +: DW]), 0);
      @(negedge clk);
      chk({tag, " R7 done single"}, done, 0);
      return;
    end
    chk({tag, " R1 request raised"}, req, 1);
    fs = 1'b0;
    for (int k = 0; k < N; k++) begin
      longint ev = tbyp ? clamp16(longint'(tv[k]) * 128) : norm_of(tv[k], p);
      longint av = $signed(evec[k*EW +: EW]);
      chk(tbyp ? {tag, " R5 bypass element"} : {tag, " R2 element"}, av, ev);
      if (av == 32767 || av == -32768) fs = 1'b1;
    end
    if (!tbyp) chk({tag, " R2 full-scale present"}, fs, 1);
    repeat (3) @(negedge clk);
    for (int k = 0; k < N; k++) begin
      er[k] = longint'($signed(evec[k*EW +: EW])) * mult;
      eres[k*RW +: RW] = RW'(er[k]);
      exp_res[k] = resc_of(er[k], s);
    end
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk({tag, " R7 done"}, done, 1);
    for (int k = 0; k < N; k++) chk({tag, " R4 rescaled"}, $signed(res[k*DW +: DW]), exp_res[k]);
    eres = '0;
    @(negedge clk);
    chk({tag, " R7 done single"}, done, 0);
    for (int k = 0; k < N; k++) chk({tag, " R7 result held"}, $signed(res[k*DW +: DW]), exp_res[k]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 busy", busy, 0);
    chk("R9 req", req, 0);
    chk("R9 done", done, 0);
    chk("R9 result", res, 0);
    rst_n = 1'b1;
    @(negedge clk);

    tv = '{3, -1, 2, 0};            tbyp = 0; mult = 1; run("small", 0);
    tv = '{-32768, 100, 32767, -5}; tbyp = 0; mult = 2; run("negpeak_sat", 0);
    tv = '{20000, -300, 5, 7};      tbyp = 0; mult = 8; run("pos_sat", 0);
    tv = '{-7, -7, 3, 1};           tbyp = 0; mult = 3; run("tie_neg", 0);
    tv = '{0, 0, 0, 0};             tbyp = 0; mult = 1; run("zero", 0);
    tv = '{256, -256, 128, -1};     tbyp = 1; mult = 1; run("bypass", 0);
    tv = '{1000, -900, 77, 0};      tbyp = 1; mult = 5; run("bypass_sat", 0);
    tv = '{0, 0, 0, 0};             tbyp = 1; mult = 1; run("bypass_zero", 0);
    tv = '{1, -2, 1, 0};            tbyp = 0; mult = 4; run("tiny", 0);
    tv = '{50, -25, 10, 1};         tbyp = 0; mult = 1; run("R8 ignore", 1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (req || busy) begin
        chk("R8 no second transaction", {req, busy}, 0);
        break;
      end
    end
    chk("R8 idle after ignore", busy, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule